// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Port

This block is a synthesizable model of the device side of a synchronous SRAM. Every access on this SRAM is a fixed burst of two words. The two clock phases of the port are modelled by one internal clock at twice the command rate. A phase register inside the block marks the edges. Edges where it is set are command edges, which stand for the rising input clock and the rising output clock. The edges in between are half edges, which stand for the rising complementary clocks. The load strobe, the read/write select and the address are sampled only on command edges.

A write takes its two data words from the input bus on the command edge and the half edge of the next cycle. The first word goes to the loaded address and the second to the address plus one. A read drives two words in the same slots of the next cycle, from the same pair of addresses, with an output-enable flag set for exactly those two beats. The pad cell combines `dq_o`, `dq_oe` and `dq_i` into the shared bus. The timing is fixed, so there is no back-pressure. Each stream is one word per internal edge, and a beat is valid only in its slot.

Top module: `b2_ddr_sram`

## Requirements
- R1: While reset is low and right after it is released, `dq_oe` is 0, and the first internal edge after release is a command edge.
- R2: A command edge with `ld_n`=1 is a no-operation: it writes nothing and gives no output beats, so the bus stays released in the next cycle.
- R3: A command edge with `ld_n`=0 and `rw`=0 starts a write. `dq_i` is stored at address A on the next command edge, and at A+1 on the half edge that follows it. `dq_oe` stays 0.
- R4: A command edge with `ld_n`=0 and `rw`=1 starts a read. After the next command edge, `dq_o` shows word A and `dq_oe`=1. After the half edge that follows, `dq_o` shows word A+1 and `dq_oe`=1.
- R5: The second beat's address is A+1 modulo 2^AW, so the top address is followed by address 0.
- R6: Commands may be issued on every command edge in any mix. Each burst completes unchanged while the next command is accepted.
- R7: A read issued one cycle after a write to the same addresses returns the newly written words.
- R8: `ld_n`, `rw` and `addr` are ignored on half edges.
- R9: If the clock stops, `dq_o` and `dq_oe` hold their last values.
- R10: `dq_oe` is 0 in every internal cycle that does not carry a read beat, including the cycles between bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Load strobe, active low, sampled on command edges |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Burst start address |
| dq_i | input | DW | Write data beat |
| dq_o | output | DW | Read data beat |
| dq_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The bound assertions check on every cycle that:
- each command edge leads to the output-enable pattern its decode requires: two driven beats for a read, none for a write or a no-operation;
- driven beats always come in pairs;
- a burst only starts on the half-edge sample;
- the port is quiet under reset.

The data itself is checked only by the bench's reference model. This covers burst address sequencing and wrap at the top address, read-after-write coherence, and back-to-back mixes. The bench also stops the clock and checks that the outputs hold.

// File: rtl/b2sram_pkg.sv
`timescale 1ns/1ps
package b2sram_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2
  } b2_op_e;
endpackage

// File: rtl/b2_phase_gen.sv
`timescale 1ns/1ps
// Marks which internal edge stands for a command (K / C) edge.
module b2_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic k_phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_phase <= 1'b1;
    else        k_phase <= ~k_phase;
  end
endmodule

// File: rtl/b2_cmd_stage.sv
`timescale 1ns/1ps
// Latches commands on command edges and keeps the second beat's context.
module b2_cmd_stage
  import b2sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_phase,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output b2_op_e        cur_op,
  output logic [AW-1:0] cur_addr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  b2_op_e        lead_op;
  logic [AW-1:0] lead_addr;
  b2_op_e        tail_op;
  logic [AW-1:0] tail_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_op   <= OP_NOP;
      lead_addr <= '0;
      tail_op   <= OP_NOP;
      tail_addr <= '0;
    end else if (k_phase) begin
      tail_op   <= lead_op;
      tail_addr <= lead_addr + ONE;
      if (!ld_n) begin
        lead_op   <= rw ? OP_RD : OP_WR;
        lead_addr <= addr;
      end else begin
        lead_op   <= OP_NOP;
      end
    end
  end

  always_comb begin
    if (k_phase) begin
      cur_op   = lead_op;
      cur_addr = lead_addr;
    end else begin
      cur_op   = tail_op;
      cur_addr = tail_addr;
    end
  end
endmodule

// File: rtl/b2_mem_array.sv
`timescale 1ns/1ps
// Single-port array, one access per internal edge, registered read.
module b2_mem_array #(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[addr];
  end
endmodule

// File: rtl/b2_ddr_sram.sv
`timescale 1ns/1ps
module b2_ddr_sram
  import b2sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);
  logic          k_phase;
  b2_op_e        cur_op;
  logic [AW-1:0] cur_addr;
  logic          mem_we;
  logic          mem_re;

  b2_phase_gen u_phase (
    .clk     (clk2x),
    .rst_n   (rst_n),
    .k_phase (k_phase)
  );

  b2_cmd_stage #(.AW(AW)) u_cmd (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .k_phase  (k_phase),
    .ld_n     (ld_n),
    .rw       (rw),
    .addr     (addr),
    .cur_op   (cur_op),
    .cur_addr (cur_addr)
  );

  assign mem_we = (cur_op == OP_WR);
  assign mem_re = (cur_op == OP_RD);

  b2_mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk2x),
    .rst_n (rst_n),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (cur_addr),
    .wdata (dq_i),
    .rdata (dq_o)
  );

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) dq_oe <= 1'b0;
    else        dq_oe <= mem_re;
  end
endmodule

// File: rtl/b2_ddr_sram_chk.sv
`timescale 1ns/1ps
module b2_ddr_sram_chk (
  input logic clk2x,
  input logic rst_n,
  input logic ld_n,
  input logic rw,
  input logic k_phase,
  input logic dq_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk2x)
    !rst_n |=> !dq_oe);

  assert_nop_idle_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
    (k_phase && ld_n) |-> ##3 !dq_oe ##1 !dq_oe);

  assert_write_no_drive_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
    (k_phase && !ld_n && !rw) |-> ##3 !dq_oe ##1 !dq_oe);

  assert_read_drive_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    (k_phase && !ld_n && rw) |-> ##3 dq_oe ##1 dq_oe);

  assert_beat_pair_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dq_oe) |=> dq_oe);

  assert_burst_phase_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dq_oe) |-> !k_phase);
endmodule

bind b2_ddr_sram b2_ddr_sram_chk u_chk (
  .clk2x   (clk2x),
  .rst_n   (rst_n),
  .ld_n    (ld_n),
  .rw      (rw),
  .k_phase (k_phase),
  .dq_oe   (dq_oe)
);

// File: tb/test_b2_ddr_sram.sv
`timescale 1ns/1ps
module test_b2_ddr_sram;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk2x = 1'b0;
  logic          run = 1'b1;
  logic          rst_n;
  logic          ld_n;
  logic          rw;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";

  b2_ddr_sram #(.AW(AW), .DW(DW)) i_b2_ddr_sram (
    .clk2x (clk2x), .rst_n (rst_n), .ld_n (ld_n), .rw (rw),
    .addr (addr), .dq_i (dq_i), .dq_o (dq_o), .dq_oe (dq_oe)
  );

  always begin
    #10;
    if (run) clk2x = ~clk2x;
  end

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: beats scheduled by absolute edge number.
  typedef struct { int due; bit wr; int a; } beat_t;
  beat_t         sched[$];
  logic [DW-1:0] mem_m [DEPTH];
  bit            known [DEPTH];
  int            ecount = 0;
  bit            live = 0;
  bit            exp_oe = 0;
  bit            exp_known = 0;
  logic [DW-1:0] exp_dq = '0;

  always @(posedge clk2x) begin
    if (rst_n) begin
      exp_oe = 0;
      while (sched.size() > 0 && sched[0].due == ecount) begin
        beat_t b;
        b = sched.pop_front();
        if (b.wr) begin
          mem_m[b.a] = dq_i;
          known[b.a] = 1;
        end else begin
          exp_oe = 1;
          exp_dq = mem_m[b.a];
          exp_known = known[b.a];
        end
      end
      if (ecount % 2 == 0 && !ld_n) begin
        sched.push_back('{ecount + 2, !rw, int'(addr)});
        sched.push_back('{ecount + 3, !rw, (int'(addr) + 1) % DEPTH});
      end
      ecount++;
      live = 1;
    end
  end

  always @(negedge clk2x) begin
    if (rst_n && live) begin
      chk(dq_oe == exp_oe, "dq_oe R10", 32'(dq_oe), 32'(exp_oe));
      if (exp_oe && exp_known)
        chk(dq_o == exp_dq, "dq_o", 32'(dq_o), 32'(exp_dq));
    end
  end

  // One command cycle: command on the command edge, junk on the half edge (R8).
  task automatic kcyc(input bit l, input bit r, input int a);
    ld_n = l; rw = r; addr = AW'(a); dq_i = DW'($urandom);
    @(negedge clk2x);
    ld_n = 1'($urandom); rw = 1'($urandom); addr = AW'($urandom); dq_i = DW'($urandom);
    @(negedge clk2x);
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_dq;
    logic          hold_oe;
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    rst_n = 0; ld_n = 1; rw = 0; addr = '0; dq_i = '0;
    repeat (3) @(negedge clk2x);
    tag = "R1";
    chk(dq_oe == 1'b0, "dq_oe in reset", 32'(dq_oe), 32'd0);
    rst_n = 1;
    kcyc(1, 0, 0);
    kcyc(1, 1, 5);
    tag = "R3";
    for (int a = 0; a < DEPTH; a += 2) kcyc(0, 0, a);
    tag = "R6";
    for (int a = 0; a < DEPTH; a += 2) kcyc(0, 1, a);
    tag = "R4";
    for (int a = 1; a < DEPTH; a += 6) begin
      kcyc(0, 1, a);
      kcyc(1, 0, 0);
    end
    tag = "R5";
    kcyc(0, 0, DEPTH - 1);
    kcyc(1, 0, 0);
    kcyc(0, 1, DEPTH - 1);
    kcyc(0, 1, 0);
    kcyc(1, 0, 0);
    tag = "R7";
    for (int i = 0; i < 8; i++) begin
      kcyc(0, 0, 9 + 4 * i);
      kcyc(0, 1, 9 + 4 * i);
    end
    kcyc(1, 0, 0);
    tag = "R2";
    for (int i = 0; i < 6; i++) kcyc(1, 1'($urandom), $urandom);
    tag = "R8";
    for (int i = 0; i < 60; i++) kcyc(1'($urandom), 1'($urandom), $urandom);
    kcyc(1, 0, 0);
    tag = "R9";
    kcyc(0, 1, 20);
    ld_n = 1;
    @(negedge clk2x);
    run = 0;
    hold_dq = dq_o;
    hold_oe = dq_oe;
    #200;
    chk(dq_o == hold_dq, "dq_o while stopped", 32'(dq_o), 32'(hold_dq));
    chk(dq_oe == hold_oe && hold_oe, "dq_oe while stopped", 32'(dq_oe), 32'd1);
    run = 1;
    @(negedge clk2x);
    kcyc(1, 0, 0);
    kcyc(1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule